// File: doc/BRIEF.md
# Paired-Sample Capture Buffer

This block records a burst of samples from two interleaved converters, one sampling on the rising clock edge and one on the falling edge. Each cycle of `sample_clk` a pair of words (one from each converter) arrives with a pair-valid strobe. An asynchronous capture request is resynchronised into the sample domain. Its rising edge arms the buffer. The first valid pair seen after arming is dropped, so the first stored entry is always a complete, ordered pair from both converters. Storing then continues until the memory holds `DEPTH` pairs, and the buffer reports itself full.

A separate asynchronous read request is resynchronised into the `read_clk` domain. When the buffer is full, its rising edge streams the whole contents out in write order, starting at the oldest pair. Each read cycle carries one pair on two parallel buses and is marked with `out_valid`. Sample words are offset-binary codes and are passed through bit for bit. Once the stream ends, the two domains complete a four-phase handshake that clears the full state, and a new capture can then be armed.

Top module: `capbuf_top`

## Requirements
- R1: While `rst_n` is low and right after reset, `out_valid`, `full` and `capturing` are 0.
- R2: A rising edge on `wen_async`, after two `sample_clk` synchroniser stages, moves an idle buffer into capture and `capturing` goes to 1.
- R3: The first cycle with `pair_vld`=1 after capture starts is discarded. The first stored entry is the second valid pair.
- R4: Stored pairs keep their arrival order and their exact 8-bit values, including 8'h00 and 8'hFF. Cycles with `pair_vld`=0 store nothing.
- R5: Once `DEPTH` pairs are stored, `full` goes to 1 and `capturing` goes to 0. Later pairs are not stored.
- R6: A `wen_async` edge while capturing or while full is ignored: stored contents and write position do not change.
- R7: A rising edge on `ren_async` (two `read_clk` synchroniser stages) while full streams exactly `DEPTH` pairs, oldest first. The streamed pairs go out on consecutive `read_clk` cycles, with `out_rise` carrying the rising-edge converter's word, `out_fall` the falling-edge converter's word, and `out_valid`=1 for each pair.
- R8: A read request while the buffer is not full produces no `out_valid`.
- R9: After the stream completes, `full` returns to 0 and a new capture can be armed.
- R10: Asserting `rst_n` low during a capture returns the buffer to idle, with `capturing` and `full` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sample_clk | input | 1 | Write-side clock, one sample pair per cycle |
| read_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rise_smp | input | SW | Rising-edge converter word, offset binary |
| fall_smp | input | SW | Falling-edge converter word, offset binary |
| pair_vld | input | 1 | The pair on `rise_smp`/`fall_smp` is valid this cycle |
| wen_async | input | 1 | Asynchronous capture request, acts on its rising edge |
| ren_async | input | 1 | Asynchronous read request, acts on its rising edge |
| out_rise | output | SW | Streamed rising-edge converter word |
| out_fall | output | SW | Streamed falling-edge converter word |
| out_valid | output | 1 | The output buses carry a stored pair |
| capturing | output | 1 | Capture is armed or filling (`sample_clk` domain) |
| full | output | 1 | `DEPTH` pairs are stored (`sample_clk` domain) |

## Verification
The hardest case to reach from the ports is the alignment drop. Which pair gets discarded depends on when the resynchronised request lands relative to the pair stream. The bench therefore holds `pair_vld` low until `capturing` shows the request has been recognised, which makes the discarded pair known and lets the first read-out entry be checked exactly. The second hard case is a fresh request arriving in the middle of a fill or while full. The bench raises `wen_async` while pairs are still flowing and again after the buffer fills, then confirms at the read port that no entry moved.

// File: rtl/capbuf_pkg.sv
`timescale 1ns/1ps
package capbuf_pkg;

  typedef enum logic [1:0] {W_IDLE, W_ALIGN, W_FILL, W_FULL} wr_state_e;
  typedef enum logic [1:0] {R_IDLE, R_STREAM, R_DONE} rd_state_e;

  // true when an address sits on the last entry of a buffer of the given depth
  function automatic logic at_last(input int unsigned idx, input int unsigned depth);
    return idx == depth - 1;
  endfunction

  function automatic logic edge_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/capbuf_sync.sv
`timescale 1ns/1ps
module capbuf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/capbuf_wr_ctrl.sv
`timescale 1ns/1ps
module capbuf_wr_ctrl
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen_s,
  input  logic          pair_vld,
  input  logic          drained_s,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic          wen_rise,
  output logic          capturing,
  output logic          full
);
  wr_state_e state;
  logic      wen_q;

  assign wen_rise  = edge_up(wen_s, wen_q);
  assign wr_fire   = (state == W_FILL) && pair_vld;
  assign capturing = (state == W_ALIGN) || (state == W_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= W_IDLE;
      waddr <= '0;
      wen_q <= 1'b0;
      full  <= 1'b0;
    end else begin
      wen_q <= wen_s;
      unique case (state)
        W_IDLE: if (wen_rise && !drained_s) begin
          state <= W_ALIGN;
          waddr <= '0;
        end
        W_ALIGN: if (pair_vld) state <= W_FILL;
        W_FILL: if (pair_vld) begin
          if (at_last(32'(waddr), DEPTH)) begin
            state <= W_FULL;
            full  <= 1'b1;
          end else begin
            waddr <= waddr + AW'(1);
          end
        end
        W_FULL: if (drained_s) begin
          state <= W_IDLE;
          full  <= 1'b0;
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/capbuf_rd_ctrl.sv
`timescale 1ns/1ps
module capbuf_rd_ctrl
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_s,
  input  logic          full_s,
  output logic          rd_req,
  output logic [AW-1:0] raddr,
  output logic          ren_rise,
  output logic          drained
);
  rd_state_e state;
  logic      ren_q;

  assign ren_rise = edge_up(ren_s, ren_q);
  assign rd_req   = (state == R_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= R_IDLE;
      raddr   <= '0;
      ren_q   <= 1'b0;
      drained <= 1'b0;
    end else begin
      ren_q <= ren_s;
      unique case (state)
        R_IDLE: if (ren_rise && full_s) begin
          state <= R_STREAM;
          raddr <= '0;
        end
        R_STREAM: begin
          if (at_last(32'(raddr), DEPTH)) begin
            state   <= R_DONE;
            drained <= 1'b1;
          end else begin
            raddr <= raddr + AW'(1);
          end
        end
        R_DONE: if (!full_s) begin
          state   <= R_IDLE;
          drained <= 1'b0;
        end
        default: state <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/capbuf_mem.sv
`timescale 1ns/1ps
module capbuf_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int W     = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          rvalid
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wclk)
    if (we) store[waddr] <= wdata;

  always_ff @(posedge rclk)
    if (re) rdata <= store[raddr];

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
endmodule

// File: rtl/capbuf_top.sv
`timescale 1ns/1ps
module capbuf_top #(
  parameter int SW          = 8,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic          sample_clk,
  input  logic          read_clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rise_smp,
  input  logic [SW-1:0] fall_smp,
  input  logic          pair_vld,
  input  logic          wen_async,
  input  logic          ren_async,
  output logic [SW-1:0] out_rise,
  output logic [SW-1:0] out_fall,
  output logic          out_valid,
  output logic          capturing,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = 2 * SW;

  // named internal events, observed by the bound checker
  logic          wen_s, ren_s, full_rs, drained, drained_ws;
  logic          wr_fire, wen_rise, rd_req, ren_rise;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] rd_word;

  capbuf_sync #(.STAGES(SYNC_STAGES)) u_wen_sync (
    .clk(sample_clk), .rst_n(rst_n), .d(wen_async), .q(wen_s));
  capbuf_sync #(.STAGES(SYNC_STAGES)) u_drn_sync (
    .clk(sample_clk), .rst_n(rst_n), .d(drained), .q(drained_ws));
  capbuf_sync #(.STAGES(SYNC_STAGES)) u_ren_sync (
    .clk(read_clk), .rst_n(rst_n), .d(ren_async), .q(ren_s));
  capbuf_sync #(.STAGES(SYNC_STAGES)) u_full_sync (
    .clk(read_clk), .rst_n(rst_n), .d(full), .q(full_rs));

  capbuf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(sample_clk), .rst_n(rst_n), .wen_s(wen_s), .pair_vld(pair_vld),
    .drained_s(drained_ws), .wr_fire(wr_fire), .waddr(waddr),
    .wen_rise(wen_rise), .capturing(capturing), .full(full));

  capbuf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk(read_clk), .rst_n(rst_n), .ren_s(ren_s), .full_s(full_rs),
    .rd_req(rd_req), .raddr(raddr), .ren_rise(ren_rise), .drained(drained));

  capbuf_mem #(.DEPTH(DEPTH), .AW(AW), .W(PW)) u_mem (
    .wclk(sample_clk), .we(wr_fire), .waddr(waddr), .wdata({rise_smp, fall_smp}),
    .rclk(read_clk), .rst_n(rst_n), .re(rd_req), .raddr(raddr),
    .rdata(rd_word), .rvalid(out_valid));

  assign out_rise = rd_word[PW-1:SW];
  assign out_fall = rd_word[SW-1:0];
endmodule

// File: rtl/capbuf_chk.sv
`timescale 1ns/1ps
module capbuf_chk #(
  parameter int DEPTH = 256
) (
  input logic sample_clk,
  input logic read_clk,
  input logic rst_n,
  input logic wr_fire,
  input logic pair_vld,
  input logic capturing,
  input logic full,
  input logic full_rs,
  input logic out_valid
);
  logic        seen_pair;
  int unsigned wcnt;
  int unsigned vcnt;

  always_ff @(posedge sample_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_pair <= 1'b0;
      wcnt      <= 0;
    end else begin
      if (!capturing) seen_pair <= 1'b0;
      else if (pair_vld) seen_pair <= 1'b1;
      if (!capturing && !full) wcnt <= 0;
      else if (wr_fire) wcnt <= wcnt + 1;
    end
  end

  always_ff @(posedge read_clk or negedge rst_n) begin
    if (!rst_n) vcnt <= 0;
    else if (!full_rs) vcnt <= 0;
    else if (out_valid) vcnt <= vcnt + 1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge sample_clk)
    !rst_n |-> (!full && !capturing));

  // R3
  align_skip_chk: assert property (@(posedge sample_clk) disable iff (!rst_n)
    wr_fire |-> seen_pair);

  // R5
  full_entry_chk: assert property (@(posedge sample_clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_fire));

  // R5
  fill_bound_chk: assert property (@(posedge sample_clk) disable iff (!rst_n)
    wr_fire |-> (wcnt < DEPTH));

  // R8
  read_gate_chk: assert property (@(posedge read_clk) disable iff (!rst_n)
    out_valid |-> full_rs);

  // R7
  read_len_chk: assert property (@(posedge read_clk) disable iff (!rst_n)
    out_valid |-> (vcnt < DEPTH));
endmodule

bind capbuf_top capbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .sample_clk(sample_clk), .read_clk(read_clk), .rst_n(rst_n),
  .wr_fire(wr_fire), .pair_vld(pair_vld), .capturing(capturing),
  .full(full), .full_rs(full_rs), .out_valid(out_valid));

// File: tb/sim_capbuf_top.sv
`timescale 1ns/1ps
module sim_capbuf_top;
  localparam int SW    = 8;
  localparam int DEPTH = 16;

  logic          sample_clk = 1'b0;
  logic          read_clk   = 1'b0;
  logic          rst_n      = 1'b0;
  logic [SW-1:0] rise_smp   = '0;
  logic [SW-1:0] fall_smp   = '0;
  logic          pair_vld   = 1'b0;
  logic          wen_async  = 1'b0;
  logic          ren_async  = 1'b0;
  logic [SW-1:0] out_rise, out_fall;
  logic          out_valid, capturing, full;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #4   sample_clk = ~sample_clk;
  always #5.5 read_clk   = ~read_clk;

  capbuf_top #(.SW(SW), .DEPTH(DEPTH)) u0 (
    .sample_clk(sample_clk), .read_clk(read_clk), .rst_n(rst_n),
    .rise_smp(rise_smp), .fall_smp(fall_smp), .pair_vld(pair_vld),
    .wen_async(wen_async), .ren_async(ren_async),
    .out_rise(out_rise), .out_fall(out_fall), .out_valid(out_valid),
    .capturing(capturing), .full(full));

  // vector: [19:12] rise seed, [11:4] fall seed, [3:1] idle gap, [0] re-request
  localparam logic [19:0] VEC [4] = '{
    {8'h00, 8'hFF, 3'd0, 1'b0},
    {8'h80, 8'h7F, 3'd1, 1'b1},
    {8'hFF, 8'h00, 3'd3, 1'b0},
    {8'h5A, 8'hA5, 3'd2, 1'b1}
  };

  function automatic logic [SW-1:0] gen_rise(input logic [SW-1:0] seed, input int k);
    return seed + SW'(k * 37);
  endfunction
  function automatic logic [SW-1:0] gen_fall(input logic [SW-1:0] seed, input int k);
    return seed ^ SW'(k * 11);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic scyc(input int n);
    repeat (n) @(negedge sample_clk);
  endtask

  task automatic capture(input logic [SW-1:0] sr, input logic [SW-1:0] sf,
                         input int gap, input bit rewen);
    @(negedge sample_clk);
    wen_async = 1'b1;
    pair_vld  = 1'b0;
    scyc(6);
    check("R2", "capturing after request", int'(capturing), 1);
    wen_async = 1'b0;
    for (int k = 0; k < DEPTH + 3; k++) begin
      rise_smp = gen_rise(sr, k);
      fall_smp = gen_fall(sf, k);
      pair_vld = 1'b1;
      if (rewen && k == 4) wen_async = 1'b1;   // R6 request during fill
      if (rewen && k == 8) wen_async = 1'b0;
      @(negedge sample_clk);
      pair_vld = 1'b0;
      scyc(gap);
    end
    scyc(3);
    check("R5", "full after DEPTH pairs", int'(full), 1);
    check("R5", "capturing off when full", int'(capturing), 0);
    if (rewen) begin
      wen_async = 1'b1;                        // R6 request while full
      scyc(6);
      wen_async = 1'b0;
      scyc(3);
      check("R6", "request while full ignored", int'(capturing), 0);
    end
  endtask

  task automatic readout(input logic [SW-1:0] sr, input logic [SW-1:0] sf);
    logic [SW-1:0] gr [DEPTH];
    logic [SW-1:0] gf [DEPTH];
    int n = 0;
    int first = -1;
    int last  = -1;
    @(negedge read_clk);
    ren_async = 1'b1;
    for (int c = 0; c < DEPTH + 15; c++) begin
      @(negedge read_clk);
      if (out_valid) begin
        if (n < DEPTH) begin
          gr[n] = out_rise;
          gf[n] = out_fall;
        end
        if (first < 0) first = c;
        last = c;
        n++;
      end
      if (c == 5) ren_async = 1'b0;
    end
    check("R7", "pairs streamed", n, DEPTH);
    check("R7", "back-to-back stream", last - first + 1, DEPTH);
    for (int j = 0; j < DEPTH && j < n; j++) begin
      if (j == 0) begin
        check("R3", "first stored rise word", int'(gr[0]), int'(gen_rise(sr, 1)));
        check("R3", "first stored fall word", int'(gf[0]), int'(gen_fall(sf, 1)));
      end else begin
        check("R4", "stored pair, R7 order", int'({gr[j], gf[j]}),
              int'({gen_rise(sr, j + 1), gen_fall(sf, j + 1)}));
      end
    end
    scyc(20);
    check("R9", "full clears after stream", int'(full), 0);
  endtask

  task automatic idle_read(input string req);
    int seen = 0;
    @(negedge read_clk);
    ren_async = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge read_clk);
      if (out_valid) seen++;
      if (c == 5) ren_async = 1'b0;
    end
    check(req, "read request while not full", seen, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    scyc(3);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "full in reset", int'(full), 0);
    check("R1", "capturing in reset", int'(capturing), 0);
    @(negedge sample_clk);
    rst_n = 1'b1;
    scyc(4);
    check("R1", "capturing after reset", int'(capturing), 0);

    idle_read("R8");

    for (int v = 0; v < 4; v++) begin
      capture(VEC[v][19:12], VEC[v][11:4], int'(VEC[v][3:1]), VEC[v][0]);
      readout(VEC[v][19:12], VEC[v][11:4]);
    end

    // R10: reset in the middle of a fill
    @(negedge sample_clk);
    wen_async = 1'b1;
    scyc(6);
    wen_async = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rise_smp = 8'h11;
      fall_smp = 8'h22;
      pair_vld = 1'b1;
      @(negedge sample_clk);
    end
    pair_vld = 1'b0;
    check("R10", "capturing before reset", int'(capturing), 1);
    rst_n = 1'b0;
    scyc(2);
    check("R10", "capturing cleared by reset", int'(capturing), 0);
    check("R10", "full cleared by reset", int'(full), 0);
    rst_n = 1'b1;
    scyc(3);
    idle_read("R8");

    capture(8'h33, 8'hCC, 0, 1'b0);
    readout(8'h33, 8'hCC);

    finish_run();
  end
endmodule